// File: doc/BRIEF.md
# Timer Channel Counting Clock and Counter

This block is one timer channel: a 16-bit up-counter whose counting clock comes from one of eight sources. Four sources are internal. They are square waves made by a free-running prescaler that divides the master clock by 2, 8, 32 and 128. The other four are a slow clock input and three external clock inputs. All of these run through two-flop synchronisers in the master clock domain.

Each source has its own edge detector. The selected source produces a one-master-cycle count enable on its rising edge, or on its falling edge when the invert control is set. A gate selector can pass that enable only while one of the synchronised external inputs is high.

A trigger input zeroes the count, but only at the next valid counting edge. A wrap from the all-ones value to zero sets a sticky overflow flag. Reading the status clears that flag. The live count and the flag are plain outputs and can be read at any time. There are no streaming data paths, so every pin is a plain control or status signal.

Top module: `timer_chan_clk`

## Requirements
- R1: After reset, `count_o` is 0 and `ovf_o` is 0.
- R2: `count_o` rises by exactly one for each valid counting edge and is observable on every cycle without stopping the count.
- R3: `src_sel_i` values 0, 1, 2 and 3 select internal clocks of master/2, master/8, master/32 and master/128. Over any window of 64, 64, 128 and 256 master cycles, the count rises by 32, 8, 4 and 2 respectively.
- R4: `src_sel_i` value 4 counts rising edges of `slow_clk_i`. Values 5, 6 and 7 count rising edges of `ext_clk_i[0]`, `[1]` and `[2]`. These inputs are synchronised, so the count changes on the third master clock edge after the input changes.
- R5: With `invert_i` = 1 the counter advances on falling edges of the selected clock and not on rising edges.
- R6: `gate_sel_i` = 0 means no gating. Values 1, 2 and 3 gate on `ext_clk_i[0]`, `[1]` and `[2]`. An edge is counted only while the synchronised gate input is high.
- R7: A one-cycle `trig_i` pulse leaves the count unchanged until the next valid counting edge. That edge loads 0, and the edge after it gives 1.
- R8: A counting edge at the all-ones value wraps the count to 0 and sets `ovf_o`. A trigger applied at any other value does not set `ovf_o`.
- R9: `ovf_o` stays set until `status_rd_i` is high for a cycle, and it is clear on the following cycle.
- R10: A wrap in the same cycle as a status read leaves `ovf_o` set.
- R11: A pending trigger that meets a counting edge at the all-ones value loads 0 once and sets `ovf_o`. The following edge gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk_i | input | 1 | Slow clock level, asynchronous |
| ext_clk_i | input | 3 | External clock levels, asynchronous |
| src_sel_i | input | 3 | Counting clock source select (0-3 internal, 4 slow, 5-7 external) |
| invert_i | input | 1 | Count on falling edges when 1 |
| gate_sel_i | input | 2 | Gate select (0 none, 1-3 external input 0-2) |
| trig_i | input | 1 | Counter reset request, applied at the next valid edge |
| status_rd_i | input | 1 | Status read strobe, clears the overflow flag |
| count_o | output | CNT_W | Live counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Several behaviours are checked by assertions on every cycle:
- the count holds whenever no count enable is present;
- the enable is a single-cycle pulse while the selection is steady;
- a trigger meeting an enable always gives zero;
- an all-ones edge always raises the flag;
- a read with no wrap always clears it;
- the fastest prescaler tap toggles every cycle.

Other behaviours only the bench's scenarios can show. These are the divide ratios per source, synchroniser latency, edge polarity, the effect of gating, the deferred trigger, and the priority between a wrap and a read or a trigger. The wrap cases are run on a second, narrower instance so that they are cheap to reach.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  // number of internal prescaled sources
  localparam int N_INT     = 4;
  // bit spacing between prescaler taps (divide ratio step of 4)
  localparam int TAP_STEP  = 2;
  // synchronised inputs: slow clock plus three external clocks
  localparam int N_SYNC    = 4;
  localparam int N_SRC     = N_INT + N_SYNC;
  localparam int SEL_W     = $clog2(N_SRC);
  localparam int GATE_W    = $clog2(N_SYNC);
  localparam int PRE_W     = TAP_STEP * (N_INT - 1) + 1;

  typedef logic [SEL_W-1:0]  src_sel_t;
  typedef logic [GATE_W-1:0] gate_sel_t;
endpackage

// File: rtl/tcc_prescale.sv
module tcc_prescale
  import tcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [N_INT-1:0] lvl_o
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < N_INT; k++) begin : g_tap
    assign lvl_o[k] = div_q[TAP_STEP*k];
  end

  // R3
  fast_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_o[0] != $past(lvl_o[0]));
endmodule

// File: rtl/tcc_sync.sv
module tcc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/tcc_edge_sel.sv
module tcc_edge_sel
  import tcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  int_lvl_i,
  input  logic [N_SYNC-1:0] sync_lvl_i,
  input  src_sel_t          src_sel_i,
  input  logic              invert_i,
  input  gate_sel_t         gate_sel_i,
  output logic              cnt_en_o
);
  logic [N_SRC-1:0] lvl, prev_q, rise, fall, edge_v;
  logic             gate_ok;

  assign lvl = {sync_lvl_i, int_lvl_i};

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_edge
    assign rise[s]   = lvl[s] & ~prev_q[s];
    assign fall[s]   = ~lvl[s] & prev_q[s];
    assign edge_v[s] = invert_i ? fall[s] : rise[s];
  end

  // gate code g (1..3) picks synchronised input g, which is external input g-1
  assign gate_ok  = (gate_sel_i == '0) ? 1'b1 : sync_lvl_i[gate_sel_i];
  assign cnt_en_o = edge_v[src_sel_i] & gate_ok;

  // R2
  en_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_o && $stable(src_sel_i) && $stable(invert_i) |=> !cnt_en_o);
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en_i,
  input  logic             trig_i,
  input  logic             status_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, ovf_q;
  logic             wrap, zero_ld;

  assign wrap    = cnt_en_i && (cnt_q == CNT_MAX);
  assign zero_ld = cnt_en_i && (trig_i || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (cnt_en_i) cnt_q <= zero_ld ? '0 : cnt_q + 1'b1;
      if (cnt_en_i)    pend_q <= 1'b0;
      else if (trig_i) pend_q <= 1'b1;
      ovf_q <= wrap | (ovf_q & ~status_rd_i);
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_i |=> $stable(count_o));
  // R7
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_i && (trig_i || pend_q) |=> count_o == '0);
  // R8
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_i && count_o == CNT_MAX |=> ovf_o);
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_i && !(cnt_en_i && count_o == CNT_MAX) |=> !ovf_o);
endmodule

// File: rtl/timer_chan_clk.sv
module timer_chan_clk
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk_i,
  input  logic [2:0]       ext_clk_i,
  input  logic [2:0]       src_sel_i,
  input  logic             invert_i,
  input  logic [1:0]       gate_sel_i,
  input  logic             trig_i,
  input  logic             status_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [N_INT-1:0]  int_lvl;
  logic [N_SYNC-1:0] sync_lvl;
  logic              cnt_en;

  tcc_prescale u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_o (int_lvl)
  );

  tcc_sync #(.W(N_SYNC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ext_clk_i, slow_clk_i}),
    .sync_o  (sync_lvl)
  );

  tcc_edge_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_lvl_i  (int_lvl),
    .sync_lvl_i (sync_lvl),
    .src_sel_i  (src_sel_i),
    .invert_i   (invert_i),
    .gate_sel_i (gate_sel_i),
    .cnt_en_o   (cnt_en)
  );

  tcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en_i    (cnt_en),
    .trig_i      (trig_i),
    .status_rd_i (status_rd_i),
    .count_o     (count_o),
    .ovf_o       (ovf_o)
  );
endmodule

// File: tb/timer_chan_clk_bench.sv
module timer_chan_clk_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic [2:0]  ext_clk = '0;
  logic [2:0]  src_sel = 3'd5;
  logic        invert = 1'b0;
  logic [1:0]  gate_sel = '0;
  logic        trig = 1'b0;
  logic        status_rd = 1'b0;
  logic [15:0] count_w16;
  logic        ovf_w16;
  logic [7:0]  count_w8;
  logic        ovf_w8;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_chan_clk u_timer_chan_clk (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk), .ext_clk_i(ext_clk),
    .src_sel_i(src_sel), .invert_i(invert), .gate_sel_i(gate_sel),
    .trig_i(trig), .status_rd_i(status_rd), .count_o(count_w16), .ovf_o(ovf_w16));

  timer_chan_clk #(.CNT_W(8)) u_timer_chan_clk_w8 (
    .clk(clk), .rst_n(rst_n), .slow_clk_i(slow_clk), .ext_clk_i(ext_clk),
    .src_sel_i(src_sel), .invert_i(invert), .gate_sel_i(gate_sel),
    .trig_i(trig), .status_rd_i(status_rd), .count_o(count_w8), .ovf_o(ovf_w8));

  // scoreboard item: sel 0 wide count, 1 wide flag, 2 narrow count, 3 narrow flag, 4 bench-measured value
  typedef struct {
    string tag;
    int    sel;
    int    exp;
    int    act;
  } sb_item_t;

  sb_item_t sbq[$];

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_val(input string tag, input int sel, input int exp, input int act = 0);
    sb_item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp; it.act = act;
    sbq.push_back(it);
  endtask

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      sb_item_t it;
      int got;
      it = sbq.pop_front();
      case (it.sel)
        0: got = int'(count_w16);
        1: got = int'(ovf_w16);
        2: got = int'(count_w8);
        3: got = int'(ovf_w8);
        default: got = it.act;
      endcase
      n_tests++;
      if (got != it.exp) begin
        n_fail++;
        $display("FAIL %s actual %0d expected %0d", it.tag, got, it.exp);
      end
    end
  end

  // idx 0..2 external clock, 3 slow clock; ends with time for the synchroniser
  task automatic pulses(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      if (idx == 3) slow_clk = 1'b1; else ext_clk[idx] = 1'b1;
      step(4);
      if (idx == 3) slow_clk = 1'b0; else ext_clk[idx] = 1'b0;
      step(4);
    end
    step(4);
  endtask

  task automatic window(input string tag, input int sel, input int cyc, input int exp);
    int c0;
    src_sel = 3'(sel);
    c0 = int'(count_w16);
    step(cyc);
    expect_val(tag, 4, exp, int'(count_w16) - c0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit seen;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_val("R1 count after reset", 0, 0);
    expect_val("R1 flag after reset", 1, 0);
    step(1);

    // R2 R4: external and slow sources
    pulses(0, 5);
    expect_val("R2 R4 ext0 count", 0, 5);
    src_sel = 3'd6; pulses(1, 3);
    expect_val("R4 ext1 count", 0, 8);
    src_sel = 3'd7; pulses(2, 2);
    expect_val("R4 ext2 count", 0, 10);
    src_sel = 3'd4; pulses(3, 4);
    expect_val("R4 slow count", 0, 14);
    // R4 latency: change counted on the third edge, not the second
    src_sel = 3'd5;
    ext_clk[0] = 1'b1; step(2);
    expect_val("R4 latency 2 edges", 0, 14);
    step(1);
    expect_val("R4 latency 3 edges", 0, 15);
    ext_clk[0] = 1'b0; step(4);

    // R5: inverted polarity
    invert = 1'b1;
    ext_clk[0] = 1'b1; step(6);
    expect_val("R5 rising ignored", 0, 15);
    ext_clk[0] = 1'b0; step(6);
    expect_val("R5 falling counted", 0, 16);
    invert = 1'b0; step(2);

    // R6: gating on ext1
    gate_sel = 2'd2;
    pulses(0, 3);
    expect_val("R6 gate low blocks", 0, 16);
    ext_clk[1] = 1'b1; step(4);
    pulses(0, 3);
    expect_val("R6 gate high passes", 0, 19);
    ext_clk[1] = 1'b0; gate_sel = 2'd0; step(4);

    // R7 R8: deferred trigger
    trig = 1'b1; step(1); trig = 1'b0;
    step(6);
    expect_val("R7 trigger deferred", 0, 19);
    pulses(0, 1);
    expect_val("R7 zero on next edge", 0, 0);
    pulses(0, 1);
    expect_val("R7 counts on from zero", 0, 1);
    expect_val("R8 trigger sets no flag", 1, 0);

    // R3: internal divide ratios
    window("R3 div2", 0, 64, 32);
    window("R3 div8", 1, 64, 8);
    window("R3 div32", 2, 128, 4);
    window("R3 div128", 3, 256, 2);
    src_sel = 3'd5; step(2);
    expect_val("R3 narrow total", 2, 47);

    // R8: wrap on narrow instance
    pulses(0, 208);
    expect_val("R8 narrow at max", 2, 255);
    expect_val("R8 flag before wrap", 3, 0);
    pulses(0, 1);
    expect_val("R8 wrap to zero", 2, 0);
    expect_val("R8 flag set on wrap", 3, 1);
    expect_val("R8 wide no flag", 1, 0);

    // R9: sticky until read
    step(20);
    expect_val("R9 flag sticky", 3, 1);
    status_rd = 1'b1; step(1); status_rd = 1'b0;
    expect_val("R9 read clears", 3, 0);

    // R11: trigger meets wrap
    pulses(0, 255);
    expect_val("R11 narrow at max", 2, 255);
    trig = 1'b1; step(1); trig = 1'b0;
    pulses(0, 1);
    expect_val("R11 zero on wrap edge", 2, 0);
    expect_val("R11 flag set", 3, 1);
    pulses(0, 1);
    expect_val("R11 single load", 2, 1);
    status_rd = 1'b1; step(1); status_rd = 1'b0;
    expect_val("R9 cleared again", 3, 0);

    // R10: wrap while read is held
    src_sel = 3'd0;
    status_rd = 1'b1;
    seen = 0;
    for (int i = 0; i < 600; i++) begin
      step(1);
      if (ovf_w8) seen = 1;
    end
    status_rd = 1'b0;
    src_sel = 3'd5;
    expect_val("R10 wrap beats read", 4, 1, int'(seen));
    step(2);
    expect_val("R10 cleared after read", 3, 0);

    step(3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule